// File: doc/BRIEF.md
# Per-Layer Weight Block Chain Allocator

This block hands out fixed-size block ids of a shared weight buffer to the layers of several neural networks and remembers, for each layer, the order in which those blocks were filled. Empty block ids sit on a free list. A prefetch request for a layer pops an id from the free list and links it onto the end of that layer's chain. A compute-start request for a layer returns the oldest block of its chain and unlinks it. When the compute work no longer needs the weights, the id is released and goes back onto the free list.

The chains are singly linked through one shared next-pointer table indexed by block id. Each layer keeps only a head and a tail pointer, so a compute task finds its weights in prefetch order without holding any address itself. Only block ids move through the block; the weight data and the memory traffic are handled elsewhere. Every request gets its reply on the cycle after it is presented. All three request kinds may be issued in the same cycle.

Top module: `wbuf_chain_alloc`

## Requirements
- R1: After reset every one of the NBLK ids is free and every layer chain is empty; allocations with no releases return ids NBLK-1, NBLK-2, ... down to 0.
- R2: An allocation request while the free list is not empty takes the id most recently put on the list (last in, first out) and reports it with alloc_ok=1 on the next cycle.
- R3: An allocation request while the free list is empty gives alloc_err=1 and alloc_ok=0 on the next cycle and changes no free list or chain state.
- R4: Take requests on a layer return that layer's ids in the order in which they were allocated to it, unaffected by traffic on other layers.
- R5: A take request on a layer with an empty chain gives take_err=1 and take_ok=0 on the next cycle and changes nothing.
- R6: A released id that is not free is put on the free list in the same cycle, so the next allocation returns it.
- R7: Releasing an id that is already free gives rel_err=1 on the next cycle and leaves the free list unchanged.
- R8: When an allocation and a release fall in the same cycle, the allocation receives the top of the free list as it stood before that cycle, and the released id becomes the new top.
- R9: When a take and an allocation target the same layer in the same cycle, the take returns the old head, and the new id joins the chain; this includes a one-block chain, after which the new id is the sole block.
- R10: Each reply flag is 1 only on the cycle after a request of its kind, and at most one of a reply's ok and err flags is 1.
- R11: The number of ids marked free always equals the depth of the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Prefetch request: allocate a block for alloc_layer |
| alloc_layer | input | LW | Layer receiving the new block |
| take_req | input | 1 | Compute-start request for take_layer |
| take_layer | input | LW | Layer whose oldest block is wanted |
| rel_req | input | 1 | Return rel_id to the free list |
| rel_id | input | IDW | Block id being released |
| alloc_ok | output | 1 | Allocation granted (one cycle after request) |
| alloc_err | output | 1 | Allocation refused, free list empty |
| alloc_id | output | IDW | Granted block id |
| take_ok | output | 1 | Take granted |
| take_err | output | 1 | Take refused, chain empty |
| take_id | output | IDW | Head block id of the requested layer |
| rel_err | output | 1 | Release refused, id already free |

## Verification
The checker watches every cycle that each request yields exactly one of ok or err a cycle later, that no reply appears without a request, that refusals of allocation only follow an empty free list, and that the free bitmap population always matches the free list depth. Which ids come back, and in what order, depends on the history of the chains and the stack, so the LIFO order of the free list, the per-layer prefetch order, the same-cycle combinations and the absence of side effects after refused requests are shown only by the bench's reference model under directed and random traffic.

// File: rtl/wbuf_chain_alloc.sv
module wbuf_chain_alloc #(
  parameter int NBLK   = 16,
  parameter int NLAYER = 4,
  localparam int IDW   = $clog2(NBLK),
  localparam int LW    = $clog2(NLAYER)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_req,
  input  logic [LW-1:0]  alloc_layer,
  input  logic           take_req,
  input  logic [LW-1:0]  take_layer,
  input  logic           rel_req,
  input  logic [IDW-1:0] rel_id,
  output logic           alloc_ok,
  output logic           alloc_err,
  output logic [IDW-1:0] alloc_id,
  output logic           take_ok,
  output logic           take_err,
  output logic [IDW-1:0] take_id,
  output logic           rel_err
);

  logic [IDW-1:0] stk  [NBLK];
  logic [IDW-1:0] nxt  [NBLK];
  logic [IDW-1:0] head [NLAYER];
  logic [IDW-1:0] tail [NLAYER];
  logic [IDW:0]   cnt;
  logic [IDW:0]   top;
  logic [NBLK-1:0]   free_map;
  logic [NLAYER-1:0] live;

  logic           a_go, t_go, r_go, t_last, same_layer, a_append;
  logic [IDW-1:0] new_id, old_head, head_next;

  assign top        = cnt - 1'b1;
  assign a_go       = alloc_req && (cnt != '0);
  assign new_id     = stk[top[IDW-1:0]];
  assign r_go       = rel_req && !free_map[rel_id];
  assign t_go       = take_req && live[take_layer];
  assign old_head   = head[take_layer];
  assign head_next  = nxt[old_head];
  assign t_last     = (old_head == tail[take_layer]);
  assign same_layer = t_go && (take_layer == alloc_layer);
  assign a_append   = a_go && live[alloc_layer] && !(same_layer && t_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) stk[i] <= IDW'(i);
      cnt      <= (IDW+1)'(NBLK);
      free_map <= '1;
    end else begin
      if (a_go && r_go) begin
        stk[top[IDW-1:0]] <= rel_id;
      end else if (a_go) begin
        cnt <= cnt - 1'b1;
      end else if (r_go) begin
        stk[cnt[IDW-1:0]] <= rel_id;
        cnt <= cnt + 1'b1;
      end
      if (a_go) free_map[new_id] <= 1'b0;
      if (r_go) free_map[rel_id] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (a_append) nxt[tail[alloc_layer]] <= new_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      for (int l = 0; l < NLAYER; l++) begin
        head[l] <= '0;
        tail[l] <= '0;
      end
    end else begin
      for (int l = 0; l < NLAYER; l++) begin
        if (a_go && alloc_layer == LW'(l)) begin
          if (!a_append) begin
            head[l] <= new_id;
            tail[l] <= new_id;
            live[l] <= 1'b1;
          end else begin
            tail[l] <= new_id;
            if (same_layer) head[l] <= head_next;
          end
        end else if (t_go && take_layer == LW'(l)) begin
          if (t_last) live[l] <= 1'b0;
          else        head[l] <= head_next;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ok  <= 1'b0;
      alloc_err <= 1'b0;
      alloc_id  <= '0;
      take_ok   <= 1'b0;
      take_err  <= 1'b0;
      take_id   <= '0;
      rel_err   <= 1'b0;
    end else begin
      alloc_ok  <= a_go;
      alloc_err <= alloc_req && !a_go;
      alloc_id  <= a_go ? new_id : '0;
      take_ok   <= t_go;
      take_err  <= take_req && !t_go;
      take_id   <= t_go ? old_head : '0;
      rel_err   <= rel_req && !r_go;
    end
  end

endmodule

// File: rtl/wbuf_chain_alloc_chk.sv
module wbuf_chain_alloc_chk #(
  parameter int NBLK = 16,
  localparam int IDW = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_req,
  input logic            take_req,
  input logic            rel_req,
  input logic            alloc_ok,
  input logic            alloc_err,
  input logic            take_ok,
  input logic            take_err,
  input logic            rel_err,
  input logic [IDW:0]    cnt,
  input logic [NBLK-1:0] free_map
);

  assert_alloc_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (alloc_ok != alloc_err));

  assert_alloc_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_req |=> (!alloc_ok && !alloc_err));

  assert_take_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> (take_ok != take_err));

  assert_take_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_req |=> (!take_ok && !take_err));

  assert_refuse_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |-> ($past(cnt) == '0));

  assert_rel_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_req));

  assert_free_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(free_map) == int'(cnt)));

  assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) <= NBLK));

endmodule

bind wbuf_chain_alloc wbuf_chain_alloc_chk #(.NBLK(NBLK)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_req(alloc_req), .take_req(take_req), .rel_req(rel_req),
  .alloc_ok(alloc_ok), .alloc_err(alloc_err),
  .take_ok(take_ok), .take_err(take_err), .rel_err(rel_err),
  .cnt(cnt), .free_map(free_map)
);

// File: tb/tb_wbuf_chain_alloc.sv
`timescale 1ns/1ps
module tb_wbuf_chain_alloc;
  localparam int NBLK = 16, NLAYER = 4;
  localparam int IDW = $clog2(NBLK), LW = $clog2(NLAYER);

  logic clk = 0, rst_n = 0;
  logic alloc_req = 0, take_req = 0, rel_req = 0;
  logic [LW-1:0] alloc_layer = '0, take_layer = '0;
  logic [IDW-1:0] rel_id = '0;
  logic alloc_ok, alloc_err, take_ok, take_err, rel_err;
  logic [IDW-1:0] alloc_id, take_id;

  always #2.5 clk = ~clk;

  wbuf_chain_alloc #(.NBLK(NBLK), .NLAYER(NLAYER)) dut (.*);

  int total = 0, bad = 0;
  int fstk[$];
  int chain[NLAYER][$];
  int held[$];
  bit isfree[NBLK];

  task automatic chk(bit cond, string tag, string what, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit a, int al, bit t, int tl, bit r, int rid, string tag);
    bit e_aok, e_tok, e_rerr;
    int e_aid, e_tid;
    int idx[$];
    e_aok  = fstk.size() > 0;
    e_aid  = e_aok ? fstk[$] : 0;
    e_tok  = chain[tl].size() > 0;
    e_tid  = e_tok ? chain[tl][0] : 0;
    e_rerr = r && isfree[rid];
    alloc_req = a; alloc_layer = LW'(al);
    take_req = t;  take_layer = LW'(tl);
    rel_req = r;   rel_id = IDW'(rid);
    @(negedge clk);
    alloc_req = 0; take_req = 0; rel_req = 0;
    if (a) begin
      chk(alloc_ok == e_aok, tag, "alloc_ok", alloc_ok, e_aok);
      chk(alloc_err == !e_aok, tag, "alloc_err", alloc_err, !e_aok);
      if (e_aok) chk(alloc_id == IDW'(e_aid), tag, "alloc_id", alloc_id, e_aid);
    end else chk(!alloc_ok && !alloc_err, "R10", "idle alloc flags", {alloc_ok, alloc_err}, 0);
    if (t) begin
      chk(take_ok == e_tok, tag, "take_ok", take_ok, e_tok);
      chk(take_err == !e_tok, tag, "take_err", take_err, !e_tok);
      if (e_tok) chk(take_id == IDW'(e_tid), tag, "take_id", take_id, e_tid);
    end else chk(!take_ok && !take_err, "R10", "idle take flags", {take_ok, take_err}, 0);
    chk(rel_err == e_rerr, tag, "rel_err", rel_err, e_rerr);
    if (t && e_tok) held.push_back(chain[tl].pop_front());
    if (a && e_aok) begin
      void'(fstk.pop_back());
      isfree[e_aid] = 0;
      chain[al].push_back(e_aid);
    end
    if (r && !e_rerr) begin
      fstk.push_back(rid);
      isfree[rid] = 1;
      idx = held.find_first_index(x) with (x == rid);
      if (idx.size() > 0) held.delete(idx[0]);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h;
    void'($urandom(32'd4242));
    for (int i = 0; i < NBLK; i++) begin fstk.push_back(i); isfree[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!alloc_ok && !alloc_err && !take_ok && !take_err && !rel_err, "R1", "reset flags",
        {alloc_ok, alloc_err, take_ok, take_err, rel_err}, 0);
    // R1 R2: drain in descending order, spread over layers
    for (int i = 0; i < NBLK; i++) step(1, i % NLAYER, 0, 0, 0, 0, "R1");
    // R3: refused, then state intact
    step(1, 1, 0, 0, 0, 0, "R3");
    step(1, 2, 0, 0, 0, 0, "R3");
    // R4: per-layer order
    for (int i = 0; i < NBLK / NLAYER; i++) step(0, 0, 1, 0, 0, 0, "R4");
    // R5: empty chain
    step(0, 0, 1, 0, 0, 0, "R5");
    // R6: release then reallocate
    h = held[1];
    step(0, 0, 0, 0, 1, h, "R6");
    step(1, 0, 0, 0, 0, 0, "R6");
    // R7: double release
    h = held[0];
    step(0, 0, 0, 0, 1, h, "R7");
    step(0, 0, 0, 0, 1, h, "R7");
    step(1, 3, 0, 0, 0, 0, "R7");
    // R8: alloc and release together
    h = held[0];
    step(0, 0, 0, 0, 1, held[1], "R8");
    step(1, 1, 0, 0, 1, h, "R8");
    step(1, 2, 0, 0, 0, 0, "R8");
    // R9: drain layer 2, single-block chain with take and alloc together
    while (chain[2].size() > 0) step(0, 0, 1, 2, 0, 0, "R4");
    h = held[0];
    step(0, 0, 0, 0, 1, h, "R9");
    step(1, 2, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, held[0], "R9");
    step(1, 2, 1, 2, 0, 0, "R9");
    step(1, 2, 1, 2, 0, 0, "R9");
    step(0, 0, 1, 2, 0, 0, "R9");
    step(1, 2, 1, 2, 0, 0, "R9");
    // random traffic
    for (int c = 0; c < 3000; c++) begin
      bit a, t, r;
      int rid;
      a = ($urandom % 3) != 0;
      t = ($urandom % 3) != 0;
      r = 0; rid = 0;
      if ($urandom % 6 == 0 && fstk.size() > 0) begin
        r = 1; rid = fstk[$urandom % fstk.size()];
      end else if (held.size() > 0 && ($urandom % 2) == 0) begin
        r = 1; rid = held[$urandom % held.size()];
      end
      step(a, $urandom % NLAYER, t, $urandom % NLAYER, r, rid, "R2");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule